// File: doc/BRIEF.md
# Endpoint Buffer Space Allocator

This block divides one shared endpoint buffer memory among sixteen endpoints. Endpoints 0 and 1 are fixed control endpoints. Endpoints 2 to 15 are programmable. Each programmable endpoint has a configuration entry with three fields: an enable bit, an isochronous bit and a 4-bit size code.

From these entries the block gives every endpoint a base address and a physical length inside the buffer. The physical length includes the hidden second half that double buffering needs. The block checks two byte budgets and flags any endpoint that breaks one of them or carries a reserved size code. It also reports which endpoints are interrupt IN endpoints in rate-feedback mode.

When a configuration entry changes, the block emits a one-cycle invalidate pulse. The buffer logic uses this pulse to discard all fill state. The block then recomputes the whole layout with a sequential walk over the endpoints, one endpoint per clock.

The walk is a two-state machine:
- `W_IDLE` waits for pending work. The transition *start* is taken when a change is pending. It clears the running totals and the flags and points the walk at endpoint 0.
- `W_WALK` handles one endpoint per cycle. The transition *advance* moves to the next index. The transition *finish* returns to `W_IDLE` after endpoint 15.
- A change that arrives during a walk is remembered. Another walk follows as soon as the current one ends.

Results are valid while `busy` is low.

Top module: `ep_space_alloc`

## Requirements
- R1: Endpoints 0 and 1 always get base 0 and base 64, each with length 64 bytes. They are single-buffered and count as non-isochronous. A write addressed to index 0 or 1 has no effect: no invalidate pulse, no walk, and no change to any table entry.
- R2: A disabled programmable endpoint gets length 0 and never sets a fault flag.
- R3: For an enabled non-isochronous endpoint, codes 0, 1, 2 and 3 select logical sizes of 8, 16, 32 and 64 bytes. The reported length is twice the logical size.
- R4: For an enabled non-isochronous endpoint, codes 8 to 11 select the same four sizes as codes 0 to 3. Bit i of `rate_fb` is high only when endpoint i uses such a code and was granted space. Bits 0 and 1 are always low.
- R5: For a non-isochronous endpoint, any code with bit 2 set (4 to 7 and 12 to 15) is reserved. Such an endpoint gets length 0 and sets `code_err`.
- R6: For an enabled isochronous endpoint, codes 0 to 15 select logical sizes of 16, 32, 48, 64, 96, 128, 160, 192, 256, 320, 384, 512, 640, 768, 896 and 1023 bytes. The reported length is twice the logical size.
- R7: Bases are contiguous in ascending index order. The base of endpoint i equals the sum of the lengths granted to endpoints 0 to i-1. This also holds for endpoints with length 0.
- R8: Granted lengths never sum to more than 2462 bytes. An endpoint that would exceed this budget gets length 0 and sets `ovf`. Later endpoints that still fit are granted normally.
- R9: Granted non-isochronous lengths, including both control endpoints, never sum to more than 512 bytes. An endpoint that would exceed this budget gets length 0 and sets `ovf`.
- R10: `busy` goes high in the cycle after a changing write. It stays high for exactly 17 cycles: one start cycle and then 16 walk cycles. If another change arrives during a walk, `busy` is extended by one more full walk.
- R11: `inval` is a one-cycle pulse in the cycle after a write to an index of 2 or higher whose value differs from the stored entry. A write of an identical value raises no pulse and starts no walk.
- R12: After reset, all programmable entries are disabled, `busy` is high and a walk runs. `fault_idx` shows the lowest index that set `ovf` or `code_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Endpoint index written |
| cfg_en | input | 1 | Enable field |
| cfg_iso | input | 1 | Isochronous field |
| cfg_code | input | 4 | Size code field |
| qry_idx | input | 4 | Endpoint index to look up |
| qry_base | output | 12 | Base address of the queried endpoint |
| qry_len | output | 12 | Physical length of the queried endpoint |
| busy | output | 1 | A walk is pending or running |
| inval | output | 1 | One-cycle pulse: buffer contents are now invalid |
| ovf | output | 1 | A budget was exceeded in the last walk |
| code_err | output | 1 | A reserved size code was seen in the last walk |
| fault_idx | output | 4 | Lowest endpoint index that faulted |
| rate_fb | output | 16 | Per-endpoint rate-feedback flags |

## Verification
The bench exercises the allocation with several kinds of input:
- A ladder of non-isochronous sizes shows whether the decode and the doubling are right.
- Rate-feedback codes show whether they land on the same sizes but set only their own flag bits.
- A full sweep of isochronous codes on one endpoint separates the isochronous table from the non-isochronous one.
- Budget sets are built to hit exactly 2462 bytes and exactly 512 bytes, followed by one endpoint past each limit. These tell an inclusive limit from an exclusive one and show that allocation continues after a refused endpoint.
- Writes to the control indices, identical rewrites and a write in the middle of a walk show whether the invalidate pulse and the restart follow only real changes.

// File: rtl/epalloc_pkg.sv
package epalloc_pkg;

    typedef struct packed {
        logic       en;
        logic       iso;
        logic [3:0] code;
    } ep_cfg_t;

    typedef enum logic [0:0] {
        W_IDLE = 1'b0,
        W_WALK = 1'b1
    } walk_state_t;

    // Logical byte count for an isochronous size code.
    function automatic logic [10:0] iso_logical(input logic [3:0] c);
        logic [10:0] r;
        unique case (c)
            4'd0:  r = 11'd16;
            4'd1:  r = 11'd32;
            4'd2:  r = 11'd48;
            4'd3:  r = 11'd64;
            4'd4:  r = 11'd96;
            4'd5:  r = 11'd128;
            4'd6:  r = 11'd160;
            4'd7:  r = 11'd192;
            4'd8:  r = 11'd256;
            4'd9:  r = 11'd320;
            4'd10: r = 11'd384;
            4'd11: r = 11'd512;
            4'd12: r = 11'd640;
            4'd13: r = 11'd768;
            4'd14: r = 11'd896;
            default: r = 11'd1023;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alloc_cfg_store.sv
module alloc_cfg_store
    import epalloc_pkg::*;
#(
    parameter int NUM_EP   = 16,
    parameter int FIXED_EP = 2,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  ep_cfg_t          wdata,
    output ep_cfg_t          ent_o [NUM_EP],
    output logic             change,
    output logic             inval
);

    ep_cfg_t ent_q [NUM_EP];
    logic    idx_ok;

    assign idx_ok = ({1'b0, widx} >= (IDX_W+1)'(FIXED_EP)) &&
                    ({1'b0, widx} <  (IDX_W+1)'(NUM_EP));
    assign change = we && idx_ok && (wdata != ent_q[widx]);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (change && (widx == IDX_W'(g)))
                ent_q[g] <= wdata;
        end
        assign ent_o[g] = ent_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inval <= 1'b0;
        else        inval <= change;
    end

    // R11
    inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |-> $past(we));

endmodule

// File: rtl/alloc_size_decode.sv
module alloc_size_decode
    import epalloc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int CTRL_BYTES = 64
) (
    input  ep_cfg_t           cfg,
    input  logic              fixed,
    output logic [ADDR_W-1:0] phys,
    output logic              bad,
    output logic              rfb,
    output logic              nonis
);

    always_comb begin
        phys  = '0;
        bad   = 1'b0;
        rfb   = 1'b0;
        nonis = 1'b0;
        if (fixed) begin
            phys  = ADDR_W'(CTRL_BYTES);
            nonis = 1'b1;
        end else if (cfg.en) begin
            if (cfg.iso) begin
                phys = ADDR_W'(iso_logical(cfg.code)) << 1;
            end else if (cfg.code[2]) begin
                bad = 1'b1;
            end else begin
                phys  = ADDR_W'(16) << cfg.code[1:0];
                nonis = 1'b1;
                rfb   = cfg.code[3];
            end
        end
    end

endmodule

// File: rtl/alloc_walker.sv
module alloc_walker
    import epalloc_pkg::*;
#(
    parameter int NUM_EP       = 16,
    parameter int FIXED_EP     = 2,
    parameter int ADDR_W       = 12,
    parameter int IDX_W        = 4,
    parameter int TOTAL_BYTES  = 2462,
    parameter int NONISO_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              change,
    input  logic [ADDR_W-1:0] phys,
    input  logic              bad,
    input  logic              rfb,
    input  logic              nonis,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              busy,
    output logic [ADDR_W-1:0] base_o [NUM_EP],
    output logic [ADDR_W-1:0] len_o  [NUM_EP],
    output logic [NUM_EP-1:0] rf_o,
    output logic              ovf,
    output logic              cerr,
    output logic [IDX_W-1:0]  fault_idx
);

    localparam int SUM_W = ADDR_W + 1;

    walk_state_t       state, state_n;
    logic              pending;
    logic              last;
    logic [SUM_W-1:0]  used_tot, used_ni, tot_next, ni_next;
    logic              fit_tot, fit_ni, grant, fault_seen;
    logic [ADDR_W-1:0] base_q [NUM_EP];
    logic [ADDR_W-1:0] len_q  [NUM_EP];

    assign last     = (cur_idx == IDX_W'(NUM_EP-1));
    assign tot_next = used_tot + SUM_W'(phys);
    assign ni_next  = used_ni + SUM_W'(phys);
    assign fit_tot  = tot_next <= SUM_W'(TOTAL_BYTES);
    assign fit_ni   = !nonis || (ni_next <= SUM_W'(NONISO_BYTES));
    assign grant    = !bad && fit_tot && fit_ni;
    assign busy     = pending || (state == W_WALK);

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            W_IDLE: if (pending) state_n = W_WALK;
            W_WALK: if (last)    state_n = W_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_n;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending    <= 1'b1;
            cur_idx    <= '0;
            used_tot   <= '0;
            used_ni    <= '0;
            ovf        <= 1'b0;
            cerr       <= 1'b0;
            fault_idx  <= '0;
            fault_seen <= 1'b0;
            rf_o       <= '0;
            for (int k = 0; k < NUM_EP; k++) begin
                base_q[k] <= '0;
                len_q[k]  <= '0;
            end
        end else begin
            pending <= change || (pending && (state != W_IDLE));
            unique case (state)
                W_IDLE: begin
                    if (pending) begin
                        cur_idx    <= '0;
                        used_tot   <= '0;
                        used_ni    <= '0;
                        ovf        <= 1'b0;
                        cerr       <= 1'b0;
                        fault_idx  <= '0;
                        fault_seen <= 1'b0;
                    end
                end
                W_WALK: begin
                    cur_idx         <= cur_idx + 1'b1;
                    base_q[cur_idx] <= used_tot[ADDR_W-1:0];
                    len_q[cur_idx]  <= grant ? phys : '0;
                    rf_o[cur_idx]   <= grant && rfb;
                    if (grant) begin
                        used_tot <= tot_next;
                        if (nonis) used_ni <= ni_next;
                    end
                    if (bad) cerr <= 1'b1;
                    if (!bad && !(fit_tot && fit_ni)) ovf <= 1'b1;
                    if (!grant && !fault_seen) begin
                        fault_idx  <= cur_idx;
                        fault_seen <= 1'b1;
                    end
                end
            endcase
        end
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_out
        assign base_o[g] = base_q[g];
        assign len_o[g]  = len_q[g];
    end

    // R8
    tot_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_tot <= SUM_W'(TOTAL_BYTES));

    // R9
    ni_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_ni <= SUM_W'(NONISO_BYTES));

    // R4
    rf_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_o[FIXED_EP-1:0] == '0);

    // R10
    walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cur_idx) == IDX_W'(NUM_EP-1));

endmodule

// File: rtl/ep_space_alloc.sv
module ep_space_alloc
    import epalloc_pkg::*;
#(
    parameter int NUM_EP       = 16,
    parameter int FIXED_EP     = 2,
    parameter int CTRL_BYTES   = 64,
    parameter int TOTAL_BYTES  = 2462,
    parameter int NONISO_BYTES = 512,
    localparam int IDX_W       = $clog2(NUM_EP),
    localparam int ADDR_W      = $clog2(TOTAL_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic              cfg_iso,
    input  logic [3:0]        cfg_code,
    input  logic [IDX_W-1:0]  qry_idx,
    output logic [ADDR_W-1:0] qry_base,
    output logic [ADDR_W-1:0] qry_len,
    output logic              busy,
    output logic              inval,
    output logic              ovf,
    output logic              code_err,
    output logic [IDX_W-1:0]  fault_idx,
    output logic [NUM_EP-1:0] rate_fb
);

    ep_cfg_t           ent [NUM_EP];
    ep_cfg_t           wdata;
    logic              change;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] phys;
    logic              bad, rfb, nonis, fixed;
    logic [ADDR_W-1:0] base_t [NUM_EP];
    logic [ADDR_W-1:0] len_t  [NUM_EP];

    assign wdata = '{en: cfg_en, iso: cfg_iso, code: cfg_code};
    assign fixed = ({1'b0, cur_idx} < (IDX_W+1)'(FIXED_EP));

    alloc_cfg_store #(.NUM_EP(NUM_EP), .FIXED_EP(FIXED_EP), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx), .wdata(wdata),
        .ent_o(ent), .change(change), .inval(inval)
    );

    alloc_size_decode #(.ADDR_W(ADDR_W), .CTRL_BYTES(CTRL_BYTES)) u_dec (
        .cfg(ent[cur_idx]), .fixed(fixed), .phys(phys),
        .bad(bad), .rfb(rfb), .nonis(nonis)
    );

    alloc_walker #(
        .NUM_EP(NUM_EP), .FIXED_EP(FIXED_EP), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .TOTAL_BYTES(TOTAL_BYTES), .NONISO_BYTES(NONISO_BYTES)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .change(change), .phys(phys), .bad(bad),
        .rfb(rfb), .nonis(nonis), .cur_idx(cur_idx), .busy(busy),
        .base_o(base_t), .len_o(len_t), .rf_o(rate_fb), .ovf(ovf),
        .cerr(code_err), .fault_idx(fault_idx)
    );

    assign qry_base = base_t[qry_idx];
    assign qry_len  = len_t[qry_idx];

    // R11
    inval_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |-> busy);

    // R1
    ctrl_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (len_t[0] == ADDR_W'(CTRL_BYTES)) && (base_t[1] == ADDR_W'(CTRL_BYTES)));

endmodule

// File: tb/sim_ep_space_alloc.sv
module sim_ep_space_alloc;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_iso = 1'b0;
    logic [3:0]  cfg_code = '0;
    logic [3:0]  qry_idx = '0;
    logic [11:0] qry_base, qry_len;
    logic        busy, inval, ovf, code_err;
    logic [3:0]  fault_idx;
    logic [15:0] rate_fb;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    ep_space_alloc u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_iso(cfg_iso), .cfg_code(cfg_code),
        .qry_idx(qry_idx), .qry_base(qry_base), .qry_len(qry_len),
        .busy(busy), .inval(inval), .ovf(ovf), .code_err(code_err),
        .fault_idx(fault_idx), .rate_fb(rate_fb)
    );

    int iso_tab [16] = '{16, 32, 48, 64, 96, 128, 160, 192,
                         256, 320, 384, 512, 640, 768, 896, 1023};

    // Behavioural model state
    logic [5:0] m_cfg [16];
    bit pend, walking, e_inval;
    int cnt;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pend = 1'b1; walking = 1'b0; cnt = 0; e_inval = 1'b0;
            for (int i = 0; i < 16; i++) m_cfg[i] = '0;
        end else begin
            bit chg;
            chg = cfg_we && (cfg_idx >= 2) && ({cfg_en, cfg_iso, cfg_code} != m_cfg[cfg_idx]);
            e_inval = chg;
            if (walking) begin
                cnt++;
                if (cnt == 16) walking = 1'b0;
            end else if (pend) begin
                walking = 1'b1; cnt = 0; pend = 1'b0;
            end
            if (chg) begin
                m_cfg[cfg_idx] = {cfg_en, cfg_iso, cfg_code};
                pend = 1'b1;
            end
        end
    end

    // Per-clock comparison of busy and invalidate (R10, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === (pend || walking), "R10", "busy", busy, pend || walking);
            chk(inval === e_inval, "R11", "inval", inval, e_inval);
        end
    end

    int e_base [16], e_len [16];
    int e_rf, e_ovf, e_cerr, e_fidx;

    task automatic model_alloc();
        int tot, ni, fseen;
        tot = 0; ni = 0; fseen = 0;
        e_rf = 0; e_ovf = 0; e_cerr = 0; e_fidx = 0;
        for (int i = 0; i < 16; i++) begin
            int len, isni, bad, rf, ok;
            len = 0; isni = 0; bad = 0; rf = 0;
            if (i < 2) begin
                len = 64; isni = 1;
            end else if (m_cfg[i][5]) begin
                if (m_cfg[i][4]) len = 2 * iso_tab[m_cfg[i][3:0]];
                else if (m_cfg[i][2]) bad = 1;
                else begin
                    len = 2 * (8 << m_cfg[i][1:0]); isni = 1; rf = m_cfg[i][3];
                end
            end
            ok = !bad && (tot + len <= 2462) && (!isni || ni + len <= 512);
            e_base[i] = tot;
            e_len[i] = ok ? len : 0;
            if (ok) begin
                tot += len;
                if (isni) ni += len;
                if (rf) e_rf |= (1 << i);
            end
            if (bad) e_cerr = 1;
            if (!bad && !ok) e_ovf = 1;
            if (!ok && !fseen) begin e_fidx = i; fseen = 1; end
        end
    endtask

    task automatic wr(int i, bit en, bit iso, int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(i); cfg_en = en; cfg_iso = iso; cfg_code = 4'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic check_table(string req);
        model_alloc();
        for (int i = 0; i < 16; i++) begin
            qry_idx = 4'(i);
            #1;
            chk(qry_base == 12'(e_base[i]), "R7", $sformatf("base ep%0d (%s)", i, req), qry_base, e_base[i]);
            chk(qry_len == 12'(e_len[i]), req, $sformatf("len ep%0d", i), qry_len, e_len[i]);
        end
        chk(rate_fb == 16'(e_rf), "R4", $sformatf("rate_fb (%s)", req), rate_fb, e_rf);
        chk(ovf == e_ovf[0], req, "ovf", ovf, e_ovf);
        chk(code_err == e_cerr[0], "R5", $sformatf("code_err (%s)", req), code_err, e_cerr);
        if (e_ovf || e_cerr)
            chk(fault_idx == 4'(e_fidx), "R12", $sformatf("fault_idx (%s)", req), fault_idx, e_fidx);
    endtask

    task automatic clear_prog();
        for (int i = 2; i < 16; i++) wr(i, 1'b0, 1'b0, 0);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        chk(busy == 1'b1, "R12", "busy after reset", busy, 1);
        chk(inval == 1'b0, "R12", "inval after reset", inval, 0);
        wait_idle();
        check_table("R12");
        check_table("R2");

        // R3 non-isochronous ladder
        for (int c = 0; c < 4; c++) wr(2 + c, 1'b1, 1'b0, c);
        wait_idle();
        check_table("R3");

        // R4 rate-feedback codes
        clear_prog();
        for (int c = 0; c < 4; c++) wr(6 + c, 1'b1, 1'b0, 8 + c);
        wait_idle();
        check_table("R4");

        // R5 reserved code, disabled neighbour with reserved code
        clear_prog();
        wr(2, 1'b1, 1'b0, 5);
        wr(3, 1'b1, 1'b1, 5);
        wr(4, 1'b0, 1'b0, 13);
        wait_idle();
        check_table("R5");

        // R6 isochronous sweep on one endpoint
        clear_prog();
        for (int c = 0; c < 16; c++) begin
            wr(2, 1'b1, 1'b1, c);
            wait_idle();
            check_table("R6");
        end

        // R8 total budget: exact fit then one refused in between
        clear_prog();
        wr(2, 1'b1, 1'b1, 15);
        wr(3, 1'b1, 1'b1, 0);
        wr(4, 1'b1, 1'b1, 15);
        wr(5, 1'b1, 1'b1, 5);
        wait_idle();
        check_table("R8");
        chk(fault_idx == 4'd4, "R8", "first offender", fault_idx, 4);

        // R9 non-isochronous budget
        clear_prog();
        for (int i = 2; i < 6; i++) wr(i, 1'b1, 1'b0, 3);
        wr(6, 1'b1, 1'b0, 0);
        wait_idle();
        check_table("R9");
        chk(fault_idx == 4'd5, "R9", "first offender", fault_idx, 5);

        // R1 writes to control indices are ignored
        wr(0, 1'b1, 1'b1, 15);
        #1;
        chk(inval == 1'b0, "R1", "inval after ctrl write", inval, 0);
        chk(busy == 1'b0, "R1", "busy after ctrl write", busy, 0);
        wr(1, 1'b1, 1'b0, 2);
        wait_idle();
        check_table("R1");

        // R11 identical rewrite
        wr(6, 1'b1, 1'b0, 0);
        #1;
        chk(inval == 1'b0, "R11", "inval after same write", inval, 0);
        chk(busy == 1'b0, "R11", "busy after same write", busy, 0);

        // R10 change during a walk
        clear_prog();
        wr(2, 1'b1, 1'b0, 1);
        repeat (5) @(negedge clk);
        wr(3, 1'b1, 1'b1, 7);
        wait_idle();
        check_table("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule